// File: doc/BRIEF.md
# Trimmed-Mean Sensor Sample Filter

This block sits between a thermal sensor readout and a result register. It takes a stream of raw 16-bit sensor codes. For each result it gathers a number of readings that depends on the mode, then emits one filtered code. In the larger modes it drops the highest and the lowest reading of the window and averages what is left. It finds the extremes on the fly from a running sum, a running maximum and a running minimum, so no sample is ever stored.

A 12-bit configuration word packs one 3-bit mode per sensing point. A separate index picks which sensing point is active. The filter reads the mode when the first sample of a window is accepted and keeps that mode for the whole window.

A small state machine runs the block. It has three states:
- `ST_IDLE`: no window is open.
- `ST_GATHER`: a window is partly collected.
- `ST_EMIT`: the result strobe is high for one cycle.

Its transitions are:
- **open**: from `ST_IDLE` or `ST_EMIT` to `ST_GATHER`, when a first sample arrives that is not also the last.
- **hold**: stay in `ST_GATHER` on an idle cycle or on a sample that is not the last.
- **finish**: from any state to `ST_EMIT`, when the final sample of a window is accepted.
- **rest**: from `ST_EMIT` to `ST_IDLE` when no sample arrives.
- **reset**: from any state to `ST_IDLE` when the synchronous reset is high.

Top module: `thermal_trim_filter`

## Requirements
- R1: Mode 000 takes one sample per window, and the result equals that sample.
- R2: Mode 001 takes two samples, and the result is floor((a+b)/2).
- R3: Mode 010 takes four samples, drops the largest and the smallest, and outputs floor(sum of the other two / 2).
- R4: Mode 011 takes six samples, drops the largest and the smallest, and outputs floor(sum of the other four / 4).
- R5: Mode 100 takes ten samples, drops the largest and the smallest, and outputs floor(sum of the other eight / 8).
- R6: Mode 101 takes eighteen samples, drops the largest and the smallest, and outputs floor(sum of the other sixteen / 16).
- R7: The mode of sensing point k is held in `cfg_word[3k+2:3k]`. The field selected by `point_sel` is the one used, and the other fields have no effect.
- R8: Mode codes 110 and 111 behave exactly like mode 000.
- R9: The mode is captured when the first sample of a window is accepted. A change of `cfg_word` or `point_sel` inside a window does not alter that window's sample count or its result.
- R10: A high `srst` at a clock edge drives `res_valid` and `res_code` to 0 and discards any partly collected window.
- R11: `res_valid` is high for exactly the one cycle after the final sample of a window is accepted. Cycles with `smp_valid` low do not count as samples.
- R12: Eighteen full-scale samples (0xFFFF) do not overflow, and the result is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| srst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 12 | Four packed 3-bit mode fields, one per sensing point |
| point_sel | input | 2 | Index of the active sensing point |
| smp_valid | input | 1 | A raw sample is presented this cycle |
| smp_code | input | 16 | Raw sensor code |
| res_valid | output | 1 | One-cycle strobe marking a new filtered result |
| res_code | output | 16 | Filtered code, held until the next result |

## Verification
The hardest situation to reach from the ports is a mode change part-way through a window. The filter must keep counting toward the captured length and must not restart with the new short mode. The bench changes the selected field to pass-through after the second sample of a six-sample window, then checks both that no early strobe appears and that the final value is the trimmed six-sample mean. The bench also interrupts a half-filled two-sample window with the reset. A stale partial sum would then show up in the value of the next window.

// File: rtl/tfilt_pkg.sv
package tfilt_pkg;
    localparam int SMP_W   = 16;
    localparam int MODE_W  = 3;
    localparam int N_POINTS = 4;
    localparam int MAX_SMP = 18;
    localparam int CNT_W   = $clog2(MAX_SMP + 1);
    localparam int SHIFT_W = 3;
    localparam int ACC_W   = SMP_W + $clog2(MAX_SMP + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_EMIT   = 2'd2
    } tf_state_e;

    typedef struct packed {
        logic [CNT_W-1:0]   count;
        logic               trim;
        logic [SHIFT_W-1:0] shift;
    } win_plan_t;

    // Window length, trimming and divide shift for each mode code
    function automatic win_plan_t plan_for(input logic [MODE_W-1:0] m);
        win_plan_t p;
        unique case (m)
            3'b001:  p = '{count: CNT_W'(2),  trim: 1'b0, shift: SHIFT_W'(1)};
            3'b010:  p = '{count: CNT_W'(4),  trim: 1'b1, shift: SHIFT_W'(1)};
            3'b011:  p = '{count: CNT_W'(6),  trim: 1'b1, shift: SHIFT_W'(2)};
            3'b100:  p = '{count: CNT_W'(10), trim: 1'b1, shift: SHIFT_W'(3)};
            3'b101:  p = '{count: CNT_W'(18), trim: 1'b1, shift: SHIFT_W'(4)};
            default: p = '{count: CNT_W'(1),  trim: 1'b0, shift: SHIFT_W'(0)};
        endcase
        return p;
    endfunction
endpackage

// File: rtl/tf_mode_select.sv
module tf_mode_select
    import tfilt_pkg::*;
#(
    parameter int POINTS = N_POINTS,
    parameter int FIELD_W = MODE_W,
    localparam int PSEL_W = $clog2(POINTS)
) (
    input  logic [POINTS*FIELD_W-1:0] cfg_word,
    input  logic [PSEL_W-1:0]         point_sel,
    output win_plan_t                 live_plan
);
    logic [FIELD_W-1:0] fields [POINTS];

    for (genvar g = 0; g < POINTS; g++) begin : g_field
        assign fields[g] = cfg_word[g*FIELD_W +: FIELD_W];
    end

    always_comb begin
        live_plan = plan_for(MODE_W'(fields[point_sel]));
    end
endmodule

// File: rtl/tf_window_ctrl.sv
module tf_window_ctrl
    import tfilt_pkg::*;
(
    input  logic            clk,
    input  logic            srst,
    input  logic            smp_valid,
    input  win_plan_t       live_plan,
    output win_plan_t       act_plan,
    output logic            win_open,
    output logic            hit,
    output logic [CNT_W-1:0] seen_cnt,
    output logic [CNT_W-1:0] held_cnt,
    output logic            res_valid
);
    tf_state_e state_q, state_d;
    win_plan_t held_q;
    logic [CNT_W-1:0] seen_q, count_now;

    assign win_open  = (state_q == ST_GATHER);
    assign act_plan  = win_open ? held_q : live_plan;
    assign count_now = win_open ? seen_q : '0;
    assign hit       = smp_valid && (CNT_W'(count_now + 1'b1) == act_plan.count);
    assign seen_cnt  = seen_q;
    assign held_cnt  = held_q.count;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_EMIT: begin
                if (hit)            state_d = ST_EMIT;
                else if (smp_valid) state_d = ST_GATHER;
                else                state_d = ST_IDLE;
            end
            ST_GATHER: begin
                if (hit) state_d = ST_EMIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (srst) state_q <= ST_IDLE;
        else      state_q <= state_d;
    end

    // window counter and captured plan
    always_ff @(posedge clk) begin
        if (srst) begin
            seen_q <= '0;
            held_q <= '{count: CNT_W'(1), trim: 1'b0, shift: '0};
        end else if (smp_valid) begin
            if (!win_open) held_q <= live_plan;
            seen_q <= hit ? '0 : CNT_W'(count_now + 1'b1);
        end
    end

    // outputs
    always_comb begin
        res_valid = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/tf_stats.sv
module tf_stats
    import tfilt_pkg::*;
#(
    parameter int DW = SMP_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_code,
    input  logic          first,
    input  logic          hit,
    input  win_plan_t     plan,
    output logic [DW-1:0] res_code
);
    logic [AW-1:0] sum_q, tot, kept;
    logic [DW-1:0] hi_q, lo_q, hi_n, lo_n, res_q;

    always_comb begin
        tot  = (first ? '0 : sum_q) + AW'(smp_code);
        hi_n = (first || smp_code > hi_q) ? smp_code : hi_q;
        lo_n = (first || smp_code < lo_q) ? smp_code : lo_q;
        kept = plan.trim ? (tot - AW'(hi_n) - AW'(lo_n)) : tot;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            sum_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            res_q <= '0;
        end else if (smp_valid) begin
            sum_q <= tot;
            hi_q  <= hi_n;
            lo_q  <= lo_n;
            if (hit) res_q <= DW'(kept >> plan.shift);
        end
    end

    assign res_code = res_q;
endmodule

// File: rtl/thermal_trim_filter.sv
module thermal_trim_filter
    import tfilt_pkg::*;
(
    input  logic                       clk,
    input  logic                       srst,
    input  logic [N_POINTS*MODE_W-1:0] cfg_word,
    input  logic [1:0]                 point_sel,
    input  logic                       smp_valid,
    input  logic [SMP_W-1:0]           smp_code,
    output logic                       res_valid,
    output logic [SMP_W-1:0]           res_code
);
    win_plan_t live_plan, act_plan;
    logic win_open, hit;
    logic [CNT_W-1:0] seen_cnt, held_cnt, live_cnt;

    assign live_cnt = live_plan.count;

    tf_mode_select #(.POINTS(N_POINTS), .FIELD_W(MODE_W)) u_sel (
        .cfg_word (cfg_word),
        .point_sel(point_sel),
        .live_plan(live_plan)
    );

    tf_window_ctrl u_ctl (
        .clk      (clk),
        .srst     (srst),
        .smp_valid(smp_valid),
        .live_plan(live_plan),
        .act_plan (act_plan),
        .win_open (win_open),
        .hit      (hit),
        .seen_cnt (seen_cnt),
        .held_cnt (held_cnt),
        .res_valid(res_valid)
    );

    tf_stats #(.DW(SMP_W), .AW(ACC_W)) u_stats (
        .clk      (clk),
        .srst     (srst),
        .smp_valid(smp_valid),
        .smp_code (smp_code),
        .first    (!win_open),
        .hit      (hit),
        .plan     (act_plan),
        .res_code (res_code)
    );
endmodule

// File: rtl/tf_checker.sv
module tf_checker
    import tfilt_pkg::*;
(
    input logic             clk,
    input logic             srst,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_code,
    input logic             res_valid,
    input logic [SMP_W-1:0] res_code,
    input logic             win_open,
    input logic [CNT_W-1:0] seen_cnt,
    input logic [CNT_W-1:0] held_cnt,
    input logic [CNT_W-1:0] live_cnt
);
    // R1 / R8: a one-sample window echoes its sample on the next cycle
    assert_pass_through_R1: assert property (@(posedge clk) disable iff (srst)
        (smp_valid && !win_open && live_cnt == CNT_W'(1))
        |=> (res_valid && res_code == $past(smp_code)));

    // R11: a result strobe always follows an accepted sample
    assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (srst)
        res_valid |-> $past(smp_valid));

    // R11: an idle input cycle never produces a strobe
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (srst)
        !smp_valid |=> !res_valid);

    // R9: an open window stays short of its captured length
    assert_window_bound_R9: assert property (@(posedge clk) disable iff (srst)
        win_open |-> (seen_cnt != '0 && seen_cnt < held_cnt));
endmodule

bind thermal_trim_filter tf_checker u_chk (
    .clk      (clk),
    .srst     (srst),
    .smp_valid(smp_valid),
    .smp_code (smp_code),
    .res_valid(res_valid),
    .res_code (res_code),
    .win_open (win_open),
    .seen_cnt (seen_cnt),
    .held_cnt (held_cnt),
    .live_cnt (live_cnt)
);

// File: tb/test_thermal_trim_filter.sv
`timescale 1ns/1ps
module test_thermal_trim_filter;
    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic [11:0] cfg_word = '0;
    logic [1:0]  point_sel = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_code = '0;
    logic        res_valid;
    logic [15:0] res_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    thermal_trim_filter i_thermal_trim_filter (
        .clk(clk), .srst(srst), .cfg_word(cfg_word), .point_sel(point_sel),
        .smp_valid(smp_valid), .smp_code(smp_code),
        .res_valid(res_valid), .res_code(res_code)
    );

    typedef struct packed {
        logic [1:0]  pt;
        logic [2:0]  md;
        logic [15:0] seed;
        logic [15:0] step;
        logic        gap;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 16'h1234, 16'h0000, 1'b0, 4'd1},   // R1
        '{2'd0, 3'd1, 16'h0101, 16'h0003, 1'b1, 4'd2},   // R2
        '{2'd1, 3'd2, 16'hF000, 16'h1357, 1'b0, 4'd3},   // R3
        '{2'd1, 3'd3, 16'h8000, 16'h3001, 1'b1, 4'd4},   // R4
        '{2'd2, 3'd4, 16'h0010, 16'h1357, 1'b0, 4'd5},   // R5
        '{2'd3, 3'd5, 16'h4321, 16'h0F0F, 1'b1, 4'd6},   // R6
        '{2'd2, 3'd6, 16'hABCD, 16'h1111, 1'b0, 4'd8},   // R8
        '{2'd3, 3'd7, 16'h0007, 16'h0000, 1'b1, 4'd8},   // R8
        '{2'd3, 3'd2, 16'h1000, 16'h0100, 1'b0, 4'd7},   // R7
        '{2'd0, 3'd5, 16'hFFFF, 16'h0000, 1'b0, 4'd12}   // R12
    };

    function automatic logic [15:0] gen(input logic [15:0] seed, step, input int i);
        return seed + 16'(i) * step;
    endfunction

    function automatic int win_len(input logic [2:0] md);
        case (md)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 10;
            3'd5: return 18;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [2:0] md, input logic [15:0] seed, step);
        int n, sh, mx, mn, s;
        n = win_len(md);
        case (n)
            2: sh = 1;  4: sh = 1;  6: sh = 2;  10: sh = 3;  18: sh = 4;
            default: sh = 0;
        endcase
        s = 0; mx = -1; mn = 65536;
        for (int i = 0; i < n; i++) begin
            int v;
            v = int'(gen(seed, step, i));
            s += v;
            if (v > mx) mx = v;
            if (v < mn) mn = v;
        end
        if (n > 2) s = s - mx - mn;
        return 16'(s >>> sh);
    endfunction

    task automatic check(input bit ok, input int req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] make_cfg(input logic [1:0] pt, input logic [2:0] md);
        logic [11:0] c;
        for (int k = 0; k < 4; k++)
            c[3*k +: 3] = (k == int'(pt)) ? md : 3'(md + 3'd3);
        return c;
    endfunction

    task automatic run_window(input logic [1:0] pt, input logic [2:0] md,
                              input logic [15:0] seed, step, input bit gap,
                              input int req, input bit mid_change);
        int n;
        bit early;
        logic [15:0] exp;
        n = win_len(md);
        exp = model(md, seed, step);
        early = 1'b0;
        cfg_word  = make_cfg(pt, md);
        point_sel = pt;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (res_valid) early = 1'b1;
            smp_valid = 1'b1;
            smp_code  = gen(seed, step, i);
            if (mid_change && i == 2) cfg_word[3*pt +: 3] = 3'd0;
            if (gap && i < n - 1) begin
                @(negedge clk);
                if (res_valid) early = 1'b1;
                smp_valid = 1'b0;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
        check(!early, req, "strobe before window end", int'(early), 0);
        check(res_valid === 1'b1, req, "strobe after final sample", int'(res_valid), 1);
        check(res_code === exp, req, "filtered value", int'(res_code), int'(exp));
        @(negedge clk);
        check(res_valid === 1'b0, 11, "strobe width R11", int'(res_valid), 0);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state
        check(res_valid === 1'b0, 10, "valid in reset", int'(res_valid), 0);
        check(res_code === 16'h0, 10, "code in reset", int'(res_code), 0);
        srst = 1'b0;

        for (int v = 0; v < NV; v++)
            run_window(VECS[v].pt, VECS[v].md, VECS[v].seed, VECS[v].step,
                       VECS[v].gap, int'(VECS[v].req), 1'b0);

        // R9: selected mode switched to pass-through inside a six-sample window
        run_window(2'd1, 3'd3, 16'h2000, 16'h0777, 1'b1, 9, 1'b1);

        // R10: reset in the middle of a two-sample window discards the partial sum
        cfg_word  = make_cfg(2'd0, 3'd1);
        point_sel = 2'd0;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_code  = 16'h1000;
        @(negedge clk);
        smp_valid = 1'b0;
        srst = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0, 10, "valid after mid-window reset", int'(res_valid), 0);
        check(res_code === 16'h0, 10, "code after mid-window reset", int'(res_code), 0);
        srst = 1'b0;
        run_window(2'd0, 3'd1, 16'h0200, 16'h0002, 1'b0, 10, 1'b0);

        // R11: back-to-back one-sample windows give back-to-back strobes
        cfg_word = make_cfg(2'd2, 3'd0);
        point_sel = 2'd2;
        @(negedge clk);
        smp_valid = 1'b1; smp_code = 16'h00AA;
        @(negedge clk);
        smp_code = 16'h00BB;
        check(res_valid === 1'b1 && res_code === 16'h00AA, 11, "first of pair",
              int'(res_code), 16'h00AA);
        @(negedge clk);
        smp_valid = 1'b0;
        check(res_valid === 1'b1 && res_code === 16'h00BB, 11, "second of pair",
              int'(res_code), 16'h00BB);
        @(negedge clk);
        check(res_valid === 1'b0, 11, "strobe drops when idle", int'(res_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule